// File: doc/BRIEF.md
# Eight-bit event timer with a shared divide chain

The block counts events in an 8-bit register that wraps from FFh to 00h and raises a sticky rollover flag for interrupt logic. Events come from one of two places. The first is the instruction-cycle tick. The second is an external clock pin, which passes through a two-stage synchroniser and counts on a selectable edge.

A single 8-bit divide chain is shared between two users, and one control bit decides which of them owns it. When the timer owns the chain, timer events are divided by 2 to 256. When the watchdog time-base owns it, the watchdog ticks are divided by 1 to 128, and the timer counts every event undivided.

Software reaches the block through two write strobes. One loads the control byte and the other loads the counter. A third strobe clears the flag. The counter value, the control byte and the flag are all visible on output ports.

Top module: `shtmr_top`

## Requirements
- R1: Each counted event adds one to `cnt_q`. When the count passes from FFh to 00h, `ovf_flag` becomes 1 on the same clock edge that `cnt_q` becomes 00h.
- R2: Once set, `ovf_flag` stays at 1 until `flag_clr` is pulsed. If a rollover and `flag_clr` happen in the same cycle, the flag ends up set.
- R3: When control bit 3 is 0, the timer owns the divide chain. The counter then advances once per 2^(rate+1) source events, where rate is control bits 2:0, giving 1:2 for rate 0 up to 1:256 for rate 7.
- R4: When control bit 3 is 1, the watchdog owns the divide chain. `wdt_out` then pulses once per 2^rate pulses of `wdt_tick`, and the counter advances on every source event.
- R5: When control bit 3 is 0, `wdt_out` repeats every `wdt_tick` pulse one cycle later, with no division.
- R6: Control bit 5 selects the event source: 0 selects `cyc_tick` and 1 selects `ext_clk`. Control bit 4 selects the active edge of `ext_clk`: 0 for rising, 1 for falling. The opposite edge does not change the count. The pin passes through two flops before its edge is taken, so an edge driven before clock edge k updates the count at edge k+2.
- R7: A `cnt_we` strobe loads `cnt_wdata` into the counter. While the timer owns the divide chain, the strobe also empties the chain. In either case, counting is then held off until two further `cyc_tick` pulses have passed.
- R8: While `sleep` is 1, the counter and the timer-side use of the divide chain stand still. The watchdog path keeps running.
- R9: Synchronous reset clears `ovf_flag` and the divide chain and sets the control byte to 3Fh. The counter keeps its value through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-cycle pulse per instruction cycle |
| ext_clk | input | 1 | External count pin, asynchronous |
| wdt_tick | input | 1 | Watchdog time-base pulse |
| sleep | input | 1 | Low-power state, freezes the timer |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: [2:0] rate, [3] chain to watchdog, [4] falling edge, [5] external source |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| flag_clr | input | 1 | Clears the rollover flag |
| cnt_q | output | 8 | Counter value |
| ctl_q | output | 8 | Control byte |
| ovf_flag | output | 1 | Sticky rollover flag |
| wdt_out | output | 1 | Divided or undivided watchdog pulse, registered |

## Verification
The hardest behaviour to reach is the partial state of the divide chain, because that state is never visible on any port. The stimulus advances the chain by one event at the 1:2 ratio, writes the counter, and then shows that a single later event no longer produces an increment. This confirms that the write emptied the chain.

The edge selection is reached by holding the pin at each level long enough for the synchroniser to settle, then reading the count after each single transition.

Exact rollover is checked by loading FDh and stepping one undivided event at a time.

// File: rtl/shtmr_pkg.sv
package shtmr_pkg;
  localparam int DATA_W = 8;
  localparam int PRE_W  = 8;
  localparam int RATE_W = $clog2(PRE_W);

  typedef struct packed {
    logic [1:0]        spare;
    logic              src_ext;
    logic              edge_fall;
    logic              pre_wdt;
    logic [RATE_W-1:0] rate;
  } ctl_t;

  localparam logic [7:0] CTL_RESET = 8'h3F;
endpackage

// File: rtl/shtmr_edge_sync.sv
module shtmr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], pin};
  end

  logic rise_seen, fall_seen;
  assign rise_seen = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign fall_seen = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];
  assign evt = fall_sel ? fall_seen : rise_seen;

  // R6: an event needs a real transition between the two oldest samples
  assert_evt_transition_R6: assert property (@(posedge clk) disable iff (rst)
    evt |-> (sh[SYNC_STAGES-1] != sh[SYNC_STAGES]));
endmodule

// File: rtl/shtmr_prescaler.sv
module shtmr_prescaler #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = $clog2(PRE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              evt,
  input  logic              wdt_mode,
  input  logic [RATE_W-1:0] rate,
  output logic              tap
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W:0]   mask_wide;
  logic [PRE_W-1:0] mask;

  // timer owner: 2^(rate+1); watchdog owner: 2^rate
  always_comb begin
    if (wdt_mode) mask_wide = ((PRE_W+1)'(1) << rate) - (PRE_W+1)'(1);
    else          mask_wide = ((PRE_W+1)'(2) << rate) - (PRE_W+1)'(1);
    mask = mask_wide[PRE_W-1:0];
  end

  assign tap = evt && ((pre & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) pre <= '0;
    else if (evt)   pre <= pre + 1'b1;
  end

  // R4: with the watchdog at rate 0 every pulse passes straight through
  assert_wdt_unity_R4: assert property (@(posedge clk) disable iff (rst)
    (wdt_mode && rate == '0 && evt) |-> tap);
  // R3: the timer never divides by less than two
  assert_timer_min_div_R3: assert property (@(posedge clk) disable iff (rst)
    (!wdt_mode && !clr && tap) |=> !tap);
endmodule

// File: rtl/shtmr_counter.sv
module shtmr_counter #(
  parameter int DATA_W      = 8,
  parameter int INHIBIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_clr,
  input  logic              cyc_tick,
  output logic [DATA_W-1:0] cnt,
  output logic              flag,
  output logic              hold
);
  localparam int HOLD_W = $clog2(INHIBIT_CYC + 1);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [HOLD_W-1:0] hold_cnt;
  logic              wrap;

  assign wrap = inc && !we && (cnt == ALL_ONES);
  assign hold = (hold_cnt != '0);

  // counter value survives reset by design
  always_ff @(posedge clk) begin
    if (we)       cnt <= wdata;
    else if (inc) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (wrap)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                   hold_cnt <= '0;
    else if (we)               hold_cnt <= HOLD_W'(INHIBIT_CYC);
    else if (cyc_tick && hold) hold_cnt <= hold_cnt - 1'b1;
  end

  assert_flag_on_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (inc && !we && cnt == ALL_ONES) |=> (flag && cnt == '0));
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
  assert_write_loads_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> (cnt == $past(wdata)));
endmodule

// File: rtl/shtmr_top.sv
module shtmr_top
  import shtmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_tick,
  input  logic              ext_clk,
  input  logic              wdt_tick,
  input  logic              sleep,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              cnt_we,
  input  logic [DATA_W-1:0] cnt_wdata,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] cnt_q,
  output logic [7:0]        ctl_q,
  output logic              ovf_flag,
  output logic              wdt_out
);
  ctl_t ctl;
  logic ext_evt, src_evt, tmr_evt, pre_evt, pre_tap, pre_clr, inc, hold;

  always_ff @(posedge clk) begin
    if (rst)         ctl <= ctl_t'(CTL_RESET);
    else if (ctl_we) ctl <= ctl_t'(ctl_wdata);
  end
  assign ctl_q = ctl;

  shtmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_clk), .fall_sel(ctl.edge_fall), .evt(ext_evt)
  );

  assign src_evt = ctl.src_ext ? ext_evt : cyc_tick;
  assign tmr_evt = src_evt && !sleep && !hold;
  assign pre_evt = ctl.pre_wdt ? wdt_tick : tmr_evt;
  assign pre_clr = cnt_we && !ctl.pre_wdt;
  assign inc     = ctl.pre_wdt ? tmr_evt : pre_tap;

  shtmr_prescaler #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .evt(pre_evt),
    .wdt_mode(ctl.pre_wdt), .rate(ctl.rate), .tap(pre_tap)
  );

  shtmr_counter #(.DATA_W(DATA_W), .INHIBIT_CYC(INHIBIT_CYC)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .we(cnt_we), .wdata(cnt_wdata),
    .flag_clr(flag_clr), .cyc_tick(cyc_tick),
    .cnt(cnt_q), .flag(ovf_flag), .hold(hold)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_out <= 1'b0;
    else     wdt_out <= ctl.pre_wdt ? pre_tap : wdt_tick;
  end

  assert_wdt_passthru_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctl.pre_wdt && wdt_tick) |=> wdt_out);
  assert_sleep_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (sleep && !cnt_we) |=> $stable(cnt_q));
  assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (hold && !cnt_we) |=> $stable(cnt_q));
endmodule

// File: tb/shtmr_top_test.sv
module shtmr_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_tick = 0, ext_clk = 0, wdt_tick = 0, sleep = 0;
  logic ctl_we = 0, cnt_we = 0, flag_clr = 0;
  logic [7:0] ctl_wdata = 0, cnt_wdata = 0;
  logic [7:0] cnt_q, ctl_q;
  logic ovf_flag, wdt_out;

  int checks = 0;
  int errors = 0;
  int wdt_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shtmr_top uut (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ext_clk(ext_clk),
    .wdt_tick(wdt_tick), .sleep(sleep), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr),
    .cnt_q(cnt_q), .ctl_q(ctl_q), .ovf_flag(ovf_flag), .wdt_out(wdt_out)
  );

  always @(negedge clk) if (wdt_out) wdt_seen++;

  // {src_ext, edge_fall, pre_wdt, rate[2:0], events[9:0], expected count[7:0]}
  localparam int NVEC = 12;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 3'd0, 10'd5,   8'd2},
    {1'b0, 1'b0, 1'b0, 3'd1, 10'd9,   8'd2},
    {1'b0, 1'b0, 1'b0, 3'd2, 10'd17,  8'd2},
    {1'b0, 1'b0, 1'b0, 3'd3, 10'd33,  8'd2},
    {1'b0, 1'b0, 1'b0, 3'd4, 10'd65,  8'd2},
    {1'b0, 1'b0, 1'b0, 3'd5, 10'd129, 8'd2},
    {1'b0, 1'b0, 1'b0, 3'd6, 10'd257, 8'd2},
    {1'b0, 1'b0, 1'b0, 3'd7, 10'd513, 8'd2},
    {1'b0, 1'b0, 1'b1, 3'd3, 10'd5,   8'd5},
    {1'b1, 1'b0, 1'b0, 3'd1, 10'd9,   8'd2},
    {1'b1, 1'b1, 1'b1, 3'd5, 10'd3,   8'd3},
    {1'b1, 1'b0, 1'b1, 3'd0, 10'd4,   8'd4}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) cyc_tick = 1;
    @(negedge clk) cyc_tick = 0;
  endtask

  task automatic wtick();
    @(negedge clk) wdt_tick = 1;
    @(negedge clk) wdt_tick = 0;
  endtask

  task automatic pin(logic v);
    @(negedge clk) ext_clk = v;
    idle(4);
  endtask

  task automatic wr_ctl(logic [7:0] v);
    @(negedge clk) begin ctl_we = 1; ctl_wdata = v; end
    @(negedge clk) ctl_we = 0;
  endtask

  task automatic wr_cnt(logic [7:0] v);
    @(negedge clk) begin cnt_we = 1; cnt_wdata = v; end
    @(negedge clk) cnt_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    check("R9 flag at reset", ovf_flag, 0);
    check("R9 ctl at reset", ctl_q, 8'h3F);
    @(negedge clk) rst = 0;
    idle(2);

    // table walk: R3 ratios, R4 undivided timer, R6 sources and edges
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] v;
      v = VEC[i];
      wr_ctl({2'b00, v[23], v[22], v[21], v[20:18]});
      wr_cnt(8'h00);
      tick(); tick();
      for (int k = 0; k < int'(v[17:8]); k++) begin
        if (v[23]) begin
          pin(v[22] ? 1'b1 : 1'b0);
          pin(v[22] ? 1'b0 : 1'b1);
          if (!v[22]) pin(1'b0);
        end else tick();
      end
      if (v[23] && v[22]) pin(1'b0);
      check(v[21] ? "R4/R6 table row" : "R3/R6 table row", cnt_q, v[7:0]);
    end

    // R6: edge selection, opposite edge ignored
    ext_clk = 0; idle(4);
    wr_ctl(8'h28); wr_cnt(8'h40); tick(); tick();
    pin(1); check("R6 rising counted", cnt_q, 8'h41);
    pin(0); check("R6 falling ignored when rising selected", cnt_q, 8'h41);
    wr_ctl(8'h38);
    pin(1); check("R6 rising ignored when falling selected", cnt_q, 8'h41);
    pin(0); check("R6 falling counted", cnt_q, 8'h42);

    // R1 exact rollover, R2 sticky flag
    wr_ctl(8'h08); flag_clr = 1; idle(1); flag_clr = 0;
    wr_cnt(8'hFD); tick(); tick();
    tick(); check("R1 FD->FE", {ovf_flag, cnt_q}, {1'b0, 8'hFE});
    tick(); check("R1 FE->FF", {ovf_flag, cnt_q}, {1'b0, 8'hFF});
    tick(); check("R1 FF->00 sets flag", {ovf_flag, cnt_q}, {1'b1, 8'h00});
    tick(); tick(); check("R2 flag sticky", ovf_flag, 1);
    @(negedge clk) flag_clr = 1; @(negedge clk) flag_clr = 0;
    check("R2 flag cleared", ovf_flag, 0);

    // R7 two-cycle inhibit after a write
    wr_cnt(8'h10);
    tick(); check("R7 first tick held", cnt_q, 8'h10);
    tick(); check("R7 second tick held", cnt_q, 8'h10);
    tick(); check("R7 counts after hold", cnt_q, 8'h11);

    // R7 write empties the timer-owned chain (1:2)
    wr_ctl(8'h00); wr_cnt(8'h00); tick(); tick();
    tick(); check("R7 chain half full", cnt_q, 8'h00);
    wr_cnt(8'h20); tick(); tick();
    tick(); check("R7 chain emptied by write", cnt_q, 8'h20);
    tick(); check("R7 chain completes", cnt_q, 8'h21);

    // R5 watchdog undivided while chain on timer
    wdt_seen = 0;
    repeat (5) wtick();
    idle(2); check("R5 watchdog passthrough", wdt_seen, 5);

    // R4 every watchdog ratio 1:1..1:128
    for (int r = 0; r < 8; r++) begin
      wr_ctl(8'h08 | 8'(r));
      wdt_seen = 0;
      repeat (3 << r) wtick();
      idle(2);
      check($sformatf("R4 watchdog rate %0d", r), wdt_seen, 3);
    end

    // R8 sleep freezes timer, watchdog keeps running
    wr_ctl(8'h08); wr_cnt(8'h70); tick(); tick();
    @(negedge clk) sleep = 1;
    tick(); tick(); tick();
    check("R8 counter frozen in sleep", cnt_q, 8'h70);
    wdt_seen = 0; wtick(); wtick(); idle(2);
    check("R8 watchdog runs in sleep", wdt_seen, 2);
    @(negedge clk) sleep = 0;
    tick(); check("R8 counts after wake", cnt_q, 8'h71);

    // R9 counter keeps value through reset
    wr_cnt(8'h5A);
    tick(); tick(); tick();
    check("R9 before reset", cnt_q, 8'h5B);
    @(negedge clk) rst = 1;
    idle(3);
    check("R9 counter kept", cnt_q, 8'h5B);
    check("R9 ctl reset", ctl_q, 8'h3F);
    check("R9 flag reset", ovf_flag, 0);
    @(negedge clk) rst = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule